// File: doc/BRIEF.md
# Write-Disturb Refresh Scheduler

This block sits between a host and the command port of a nonvolatile data array. Every write to any cell slightly degrades the charge in every other cell. Cells that are rarely written, such as calibration or configuration words, can therefore drift after enough writes land elsewhere in the array. The scheduler counts the host writes it passes to the array. When that count reaches a programmed threshold, it walks a programmed address window. For each cell in the window it reads the cell and then writes the same value straight back.

Host traffic keeps priority throughout. The scan yields to the host between one read/write-back pair and the next. Once the scan has started a pair, the host waits until that pair finishes. When the last write-back of the window is issued, the write counter returns to zero. The write-backs themselves are never counted.

The host request side is a valid/ready stream. A request stays on the bus with its fields stable until the cycle in which `host_req_ready` is high. `host_rsp_valid` is a one-cycle pulse that cannot be held back, so the host must always accept read data. The array side is a command strobe gated by the array's busy flag. The array must raise `mem_busy` in the cycle after it takes a command. It holds `mem_busy` until the command has finished. For a read, it pulses `mem_rd_valid` with the data in the cycle where `mem_busy` falls. The threshold must be set well below the array's disturb limit. The window must cover only static cells.

Top module: `refresh_sched`

## Requirements
- R1: Each host write accepted on the request stream adds one to an internal write count. A scan starts when the count is at least `cfg_threshold`. A threshold of zero never starts a scan.
- R2: A scan reads each address from the low bound upward to the high bound, one at a time. Each read is followed by a write to the same address. That write carries exactly the data returned by the read.
- R3: Refresh write-backs do not add to the write count. The count returns to zero when the last write-back is issued, so a further full threshold of host writes is needed before the next scan.
- R4: Between pairs, a waiting host request is accepted before the next refresh read. Between a refresh read and its write-back, `host_req_ready` stays low.
- R5: A command is presented on the array port only in a cycle where `mem_busy` is low, and at most one command is presented per cycle.
- R6: Read data for the host appears on `host_rsp_valid`/`host_rsp_data` exactly once per accepted host read. Data from refresh reads never appears there.
- R7: `refresh_active` is high from the first cycle of a scan until the cycle after the last write-back is issued. No refresh command is issued while it is low.
- R8: If the high bound is below the low bound, the scan refreshes only the cell at the low bound.
- R9: After reset, no scan is running, the count is zero, no command or response is presented, and `host_req_ready` follows `!mem_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_range_lo | input | AW | First address of the refresh window |
| cfg_range_hi | input | AW | Last address of the refresh window |
| cfg_threshold | input | CW | Write count that starts a scan (0 disables scans) |
| host_req_valid | input | 1 | Host request present |
| host_req_ready | output | 1 | Request accepted this cycle when valid is also high |
| host_req_write | input | 1 | 1 = write, 0 = read |
| host_req_addr | input | AW | Host address |
| host_req_wdata | input | DW | Host write data |
| host_rsp_valid | output | 1 | Host read data valid (single-cycle pulse) |
| host_rsp_data | output | DW | Host read data |
| mem_cmd_valid | output | 1 | Command strobe to the array |
| mem_cmd_write | output | 1 | 1 = write command, 0 = read command |
| mem_cmd_addr | output | AW | Command address |
| mem_cmd_wdata | output | DW | Command write data |
| mem_busy | input | 1 | Array is executing a command |
| mem_rd_valid | input | 1 | Read data from the array is valid |
| mem_rd_data | input | DW | Read data from the array |
| refresh_active | output | 1 | A refresh scan is in progress |

## Verification
Two things can fall in the same cycle. One is a host request reaching the block. The other is a scan deciding to start its next refresh read, as `mem_busy` drops between pairs. In that cycle the read data of an earlier host read can also return while the scan is ready to issue. Random host traffic with a random array latency of one to three cycles, run while scans are live, produces these collisions many times over. A port monitor judges each one. It checks that only one command leaves the block in that cycle, and that the host is served first. It checks that the returning data reaches the host rather than the scan. It also checks that each write-back matches the bench's own image of the array.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WAIT,
    ST_WBACK
  } scan_st_t;
endpackage

// File: rtl/rfs_wr_counter.sv
module rfs_wr_counter #(
  parameter int CW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          clr,
  input  logic [CW-1:0] threshold,
  output logic          due
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [CW-1:0] cnt_q;

  // Saturating count of host writes; a completed scan clears it.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (inc && (cnt_q != CNT_MAX)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign due = (threshold != '0) && (cnt_q >= threshold);
endmodule

// File: rtl/rfs_scan_seq.sv
module rfs_scan_seq
  import rfs_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          due,
  input  logic          mem_busy,
  input  logic          host_pending,
  input  logic          mem_rd_valid,
  input  logic [DW-1:0] mem_rd_data,
  input  logic [AW-1:0] range_lo,
  input  logic [AW-1:0] range_hi,
  output logic          ref_cmd_valid,
  output logic          ref_cmd_we,
  output logic [AW-1:0] ref_addr,
  output logic [DW-1:0] ref_wdata,
  output logic          host_allow,
  output logic          rsp_is_ref,
  output logic          scan_done,
  output logic          active
);
  scan_st_t      st_q;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] hi_q;
  logic [DW-1:0] data_q;
  logic          last_cell;

  assign last_cell     = (addr_q >= hi_q);
  assign ref_cmd_valid = !mem_busy &&
                         (((st_q == ST_READ) && !host_pending) || (st_q == ST_WBACK));
  assign ref_cmd_we    = (st_q == ST_WBACK);
  assign ref_addr      = addr_q;
  assign ref_wdata     = data_q;
  assign host_allow    = (st_q == ST_IDLE) || (st_q == ST_READ);
  assign rsp_is_ref    = (st_q == ST_WAIT);
  assign scan_done     = (st_q == ST_WBACK) && !mem_busy && last_cell;
  assign active        = (st_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      hi_q   <= '0;
      data_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (due) begin
            addr_q <= range_lo;
            hi_q   <= range_hi;
            st_q   <= ST_READ;
          end
        end
        ST_READ: begin
          if (ref_cmd_valid) st_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rd_valid) begin
            data_q <= mem_rd_data;
            st_q   <= ST_WBACK;
          end
        end
        ST_WBACK: begin
          if (!mem_busy) begin
            if (last_cell) begin
              st_q <= ST_IDLE;
            end else begin
              addr_q <= addr_q + 1'b1;
              st_q   <= ST_READ;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rfs_port_mux.sv
module rfs_port_mux #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          host_req_valid,
  input  logic          host_req_write,
  input  logic [AW-1:0] host_req_addr,
  input  logic [DW-1:0] host_req_wdata,
  input  logic          host_allow,
  input  logic          mem_busy,
  input  logic          ref_cmd_valid,
  input  logic          ref_cmd_we,
  input  logic [AW-1:0] ref_addr,
  input  logic [DW-1:0] ref_wdata,
  input  logic          mem_rd_valid,
  input  logic          rsp_is_ref,
  output logic          host_req_ready,
  output logic          host_wr_fire,
  output logic          host_rsp_valid,
  output logic          mem_cmd_valid,
  output logic          mem_cmd_write,
  output logic [AW-1:0] mem_cmd_addr,
  output logic [DW-1:0] mem_cmd_wdata
);
  logic host_fire;

  assign host_req_ready = host_allow && !mem_busy;
  assign host_fire      = host_req_valid && host_req_ready;
  assign host_wr_fire   = host_fire && host_req_write;

  always_comb begin
    mem_cmd_valid = host_fire || ref_cmd_valid;
    if (host_fire) begin
      mem_cmd_write = host_req_write;
      mem_cmd_addr  = host_req_addr;
      mem_cmd_wdata = host_req_wdata;
    end else begin
      mem_cmd_write = ref_cmd_we;
      mem_cmd_addr  = ref_addr;
      mem_cmd_wdata = ref_wdata;
    end
  end

  assign host_rsp_valid = mem_rd_valid && !rsp_is_ref;
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int CW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_range_lo,
  input  logic [AW-1:0] cfg_range_hi,
  input  logic [CW-1:0] cfg_threshold,
  input  logic          host_req_valid,
  output logic          host_req_ready,
  input  logic          host_req_write,
  input  logic [AW-1:0] host_req_addr,
  input  logic [DW-1:0] host_req_wdata,
  output logic          host_rsp_valid,
  output logic [DW-1:0] host_rsp_data,
  output logic          mem_cmd_valid,
  output logic          mem_cmd_write,
  output logic [AW-1:0] mem_cmd_addr,
  output logic [DW-1:0] mem_cmd_wdata,
  input  logic          mem_busy,
  input  logic          mem_rd_valid,
  input  logic [DW-1:0] mem_rd_data,
  output logic          refresh_active
);
  logic          due;
  logic          host_wr_fire;
  logic          scan_done;
  logic          ref_cmd_valid;
  logic          ref_cmd_we;
  logic [AW-1:0] ref_addr;
  logic [DW-1:0] ref_wdata;
  logic          host_allow;
  logic          rsp_is_ref;

  rfs_wr_counter #(.CW(CW)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc       (host_wr_fire),
    .clr       (scan_done),
    .threshold (cfg_threshold),
    .due       (due)
  );

  rfs_scan_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .due           (due),
    .mem_busy      (mem_busy),
    .host_pending  (host_req_valid),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_data   (mem_rd_data),
    .range_lo      (cfg_range_lo),
    .range_hi      (cfg_range_hi),
    .ref_cmd_valid (ref_cmd_valid),
    .ref_cmd_we    (ref_cmd_we),
    .ref_addr      (ref_addr),
    .ref_wdata     (ref_wdata),
    .host_allow    (host_allow),
    .rsp_is_ref    (rsp_is_ref),
    .scan_done     (scan_done),
    .active        (refresh_active)
  );

  rfs_port_mux #(.AW(AW), .DW(DW)) u_mux (
    .host_req_valid (host_req_valid),
    .host_req_write (host_req_write),
    .host_req_addr  (host_req_addr),
    .host_req_wdata (host_req_wdata),
    .host_allow     (host_allow),
    .mem_busy       (mem_busy),
    .ref_cmd_valid  (ref_cmd_valid),
    .ref_cmd_we     (ref_cmd_we),
    .ref_addr       (ref_addr),
    .ref_wdata      (ref_wdata),
    .mem_rd_valid   (mem_rd_valid),
    .rsp_is_ref     (rsp_is_ref),
    .host_req_ready (host_req_ready),
    .host_wr_fire   (host_wr_fire),
    .host_rsp_valid (host_rsp_valid),
    .mem_cmd_valid  (mem_cmd_valid),
    .mem_cmd_write  (mem_cmd_write),
    .mem_cmd_addr   (mem_cmd_addr),
    .mem_cmd_wdata  (mem_cmd_wdata)
  );

  assign host_rsp_data = mem_rd_data;
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_req_valid,
  input logic          host_req_ready,
  input logic          host_rsp_valid,
  input logic          mem_cmd_valid,
  input logic          mem_cmd_write,
  input logic [AW-1:0] mem_cmd_addr,
  input logic [DW-1:0] mem_cmd_wdata,
  input logic          mem_busy,
  input logic          mem_rd_valid,
  input logic [DW-1:0] mem_rd_data,
  input logic          refresh_active
);
  logic          ref_cmd;
  logic          pair_open;
  logic [AW-1:0] rd_addr_q;
  logic [DW-1:0] rd_data_q;

  assign ref_cmd = mem_cmd_valid && !(host_req_valid && host_req_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pair_open <= 1'b0;
      rd_addr_q <= '0;
      rd_data_q <= '0;
    end else begin
      if (ref_cmd && !mem_cmd_write) begin
        pair_open <= 1'b1;
        rd_addr_q <= mem_cmd_addr;
      end else if (ref_cmd && mem_cmd_write) begin
        pair_open <= 1'b0;
      end
      if (mem_rd_valid && pair_open) rd_data_q <= mem_rd_data;
    end
  end

  // R2: write-back goes to the address just read
  a_r2_wb_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_cmd && mem_cmd_write) |-> (mem_cmd_addr == rd_addr_q));
  // R2: write-back carries the data just read
  a_r2_wb_data: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_cmd && mem_cmd_write) |-> (mem_cmd_wdata == rd_data_q));
  // R4: host is held off inside a read/write-back pair
  a_r4_no_host_mid_pair: assert property (@(posedge clk) disable iff (!rst_n)
    pair_open |-> !host_req_ready);
  // R5: commands only while the array is idle
  a_r5_cmd_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid |-> !mem_busy);
  // R6: refresh read data never reaches the host
  a_r6_rsp_owner: assert property (@(posedge clk) disable iff (!rst_n)
    host_rsp_valid |-> !pair_open);
  // R7: refresh commands only during a scan
  a_r7_ref_cmd_active: assert property (@(posedge clk) disable iff (!rst_n)
    ref_cmd |-> refresh_active);
  // R7: a scan ends only right after a write-back
  a_r7_ends_on_wback: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(refresh_active) |-> $past(ref_cmd && mem_cmd_write));
endmodule

bind refresh_sched refresh_sched_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .host_req_valid (host_req_valid),
  .host_req_ready (host_req_ready),
  .host_rsp_valid (host_rsp_valid),
  .mem_cmd_valid  (mem_cmd_valid),
  .mem_cmd_write  (mem_cmd_write),
  .mem_cmd_addr   (mem_cmd_addr),
  .mem_cmd_wdata  (mem_cmd_wdata),
  .mem_busy       (mem_busy),
  .mem_rd_valid   (mem_rd_valid),
  .mem_rd_data    (mem_rd_data),
  .refresh_active (refresh_active)
);

// File: tb/refresh_sched_bench.sv
module refresh_sched_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int CW = 20;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] cfg_range_lo = '0;
  logic [AW-1:0] cfg_range_hi = '0;
  logic [CW-1:0] cfg_threshold = '0;
  logic          host_req_valid = 1'b0;
  logic          host_req_ready;
  logic          host_req_write = 1'b0;
  logic [AW-1:0] host_req_addr = '0;
  logic [DW-1:0] host_req_wdata = '0;
  logic          host_rsp_valid;
  logic [DW-1:0] host_rsp_data;
  logic          mem_cmd_valid;
  logic          mem_cmd_write;
  logic [AW-1:0] mem_cmd_addr;
  logic [DW-1:0] mem_cmd_wdata;
  logic          mem_busy;
  logic          mem_rd_valid;
  logic [DW-1:0] mem_rd_data;
  logic          refresh_active;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int scans_seen = 0;
  int rsp_seen = 0;
  int reads_done = 0;

  logic [DW-1:0] shadow [DEPTH];
  logic [DW-1:0] marr [DEPTH];

  always #(CLK_PERIOD / 2) clk = ~clk;

  refresh_sched #(.AW(AW), .DW(DW), .CW(CW)) u_refresh_sched (.*);

  function automatic logic [DW-1:0] init_val(input int i);
    return DW'((i * 37 + 11) % 251);
  endfunction

  function automatic int exp_cells(input int lo, input int hi);
    return (hi >= lo) ? (hi - lo + 1) : 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Array model: random latency 1..3, read data on the cycle busy drops.
  int            lat;
  logic          pend_rd;
  logic [AW-1:0] pend_addr;
  always @(posedge clk) begin
    mem_rd_valid <= 1'b0;
    if (!rst_n) begin
      mem_busy <= 1'b0;
      lat      <= 0;
      pend_rd  <= 1'b0;
      pend_addr <= '0;
      mem_rd_data <= '0;
      for (int i = 0; i < DEPTH; i++) marr[i] <= init_val(i);
    end else if (mem_cmd_valid) begin
      mem_busy  <= 1'b1;
      lat       <= $urandom_range(1, 3);
      pend_rd   <= !mem_cmd_write;
      pend_addr <= mem_cmd_addr;
      if (mem_cmd_write) marr[mem_cmd_addr] <= mem_cmd_wdata;
    end else if (mem_busy) begin
      if (lat <= 1) begin
        mem_busy <= 1'b0;
        if (pend_rd) begin
          mem_rd_valid <= 1'b1;
          mem_rd_data  <= marr[pend_addr];
        end
      end
      lat <= lat - 1;
    end
  end

  // Port monitor, sampled well after the falling edge.
  int            exp_addr = 0;
  int            last_rd = 0;
  int            scan_lo = 0;
  int            scan_hi = 0;
  int            wb_count = 0;
  logic          prev_active = 1'b0;
  always @(negedge clk) begin
    #3;
    if (rst_n) begin
      if (host_rsp_valid) rsp_seen++;
      if (mem_cmd_valid) chk(!mem_busy, "R5 cmd while busy", int'(mem_busy), 0);
      if (refresh_active && !prev_active) begin
        scans_seen++;
        scan_lo  = int'(cfg_range_lo);
        scan_hi  = int'(cfg_range_hi);
        exp_addr = scan_lo;
        wb_count = 0;
      end
      if (mem_cmd_valid && !(host_req_valid && host_req_ready)) begin
        chk(refresh_active, "R7 refresh cmd outside scan", int'(refresh_active), 1);
        if (!mem_cmd_write) begin
          chk(int'(mem_cmd_addr) == exp_addr, "R2 refresh read order",
              int'(mem_cmd_addr), exp_addr);
          last_rd = int'(mem_cmd_addr);
        end else begin
          chk(int'(mem_cmd_addr) == last_rd, "R2 write-back address",
              int'(mem_cmd_addr), last_rd);
          chk(mem_cmd_wdata == shadow[mem_cmd_addr], "R2 write-back data",
              int'(mem_cmd_wdata), int'(shadow[mem_cmd_addr]));
          wb_count++;
          exp_addr = int'(mem_cmd_addr) + 1;
        end
      end
      if (!refresh_active && prev_active)
        chk(wb_count == exp_cells(scan_lo, scan_hi), "R2 R8 cells per scan",
            wb_count, exp_cells(scan_lo, scan_hi));
      prev_active = refresh_active;
    end
  end

  task automatic host_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int   waited;
    logic was_active;
    @(negedge clk);
    host_req_valid = 1'b1; host_req_write = 1'b1;
    host_req_addr = a; host_req_wdata = d;
    waited = 0;
    #1;
    was_active = refresh_active;
    while (!host_req_ready) begin
      @(negedge clk); #1; waited++;
    end
    @(posedge clk);
    shadow[a] = d;
    #1 host_req_valid = 1'b0;
    if (was_active) chk(waited <= 14, "R4 host wait during scan", waited, 14);
  endtask

  task automatic host_read(input logic [AW-1:0] a);
    int guard;
    @(negedge clk);
    host_req_valid = 1'b1; host_req_write = 1'b0; host_req_addr = a;
    #1;
    while (!host_req_ready) begin
      @(negedge clk); #1;
    end
    @(posedge clk);
    #1 host_req_valid = 1'b0;
    guard = 0;
    do begin
      @(negedge clk); #2; guard++;
    end while (!host_rsp_valid && guard < 50);
    reads_done++;
    chk(host_rsp_valid && host_rsp_data == shadow[a], "R6 host read data",
        int'(host_rsp_data), int'(shadow[a]));
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scan_end();
    int guard = 0;
    settle(4);
    while (refresh_active && guard < 2000) begin
      settle(1); guard++;
    end
  endtask

  initial begin
    int unsigned sd;
    sd = $urandom(32'd2024);
    for (int i = 0; i < DEPTH; i++) shadow[i] = init_val(i);
    settle(4);
    #3;
    // R9: state during and right after reset
    chk(!refresh_active && !mem_cmd_valid && !host_rsp_valid, "R9 reset outputs",
        int'(refresh_active), 0);
    rst_n = 1'b1;
    settle(1); #3;
    chk(host_req_ready == 1'b1, "R9 ready after reset", int'(host_req_ready), 1);

    // R1: threshold reached only on the fourth write
    cfg_threshold = 4; cfg_range_lo = 10; cfg_range_hi = 15;
    for (int i = 0; i < 3; i++) host_write(AW'(100 + i), DW'(i + 1));
    settle(20);
    chk(scans_seen == 0, "R1 no scan below threshold", scans_seen, 0);
    host_write(103, 8'h5a);
    settle(3);
    chk(scans_seen == 1, "R1 scan at threshold", scans_seen, 1);
    chk(refresh_active, "R7 active during scan", int'(refresh_active), 1);
    wait_scan_end();

    // R3: write-backs not counted, count cleared at scan end
    for (int i = 0; i < 3; i++) host_write(AW'(120 + i), DW'(7 * i));
    settle(20);
    chk(scans_seen == 1, "R3 count cleared after scan", scans_seen, 1);
    host_write(130, 8'h33);
    settle(3);
    chk(scans_seen == 2, "R3 next scan after full threshold", scans_seen, 2);
    wait_scan_end();

    // R8: reversed window refreshes the low-bound cell only
    cfg_range_lo = 20; cfg_range_hi = 18;
    for (int i = 0; i < 4; i++) host_write(AW'(200 + i), DW'(i));
    wait_scan_end();
    chk(scans_seen == 3, "R8 reversed window scan", scans_seen, 3);

    // R1: threshold zero never starts a scan
    cfg_threshold = 0;
    for (int i = 0; i < 6; i++) host_write(AW'(140 + i), DW'(i + 9));
    settle(20);
    chk(scans_seen == 3, "R1 zero threshold disables", scans_seen, 3);

    // Random mix with scans live: R2 R4 R5 R6
    cfg_threshold = 5; cfg_range_lo = 0; cfg_range_hi = 31;
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a;
      a = ($urandom_range(0, 1) == 0) ? AW'($urandom_range(0, 31))
                                      : AW'($urandom_range(0, DEPTH - 1));
      if ($urandom_range(0, 2) == 0) host_read(a);
      else host_write(a, DW'($urandom_range(0, 255)));
      settle($urandom_range(0, 3));
    end
    wait_scan_end();
    chk(scans_seen > 5, "R1 scans during random traffic", scans_seen, 6);
    for (int i = 0; i < 32; i++) host_read(AW'(i));
    settle(5);
    chk(rsp_seen == reads_done, "R6 one response per host read", rsp_seen, reads_done);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule